// File: doc/BRIEF.md
# Chained FIFO Slice with Ring Token Handoff

This block is a FIFO built from identical storage slices joined in a ring. Every slice sees the same write strobe, write data, read strobe and reset. At any moment exactly one slice holds the right to accept writes, and exactly one slice, which may be a different one, holds the right to serve reads. A slice that fills its last physical location while writing passes the write right to the next slice in the ring. It does this with a one-cycle write-handoff strobe. Reading works the same way, with a separate read-handoff strobe. The receiving slice continues at its own first location. A low first-load input marks the one slice that holds both rights when reset is released.

Each slice keeps its own active-low full and empty flags, computed from its own pointers. The top level combines them by OR. The combined full flag therefore goes low only when every slice is full, and the combined empty flag goes low only when every slice is empty.

Read data is registered inside the slice that serves the read. Every slice without the read right drives zeros, so the shared read bus is an OR of all slices. The slice depth must be a power of two of at least 2. The total capacity is the number of slices times the slice depth.

Top module: `chain_fifo`

## Requirements
- R1: While reset is high and right after it falls, `empty_n` is 0, `full_n` is 1, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: Words come out in the order they were accepted, with no loss or duplication, including across every slice boundary.
- R3: `full_n` is 0 exactly when NSLICE*SLICE_DEPTH words are held. A write while full is dropped, and the dropped word never appears at the output.
- R4: `empty_n` is 0 exactly when no word is held. A read while empty produces no `rd_valid` and leaves the contents unchanged.
- R5: Exactly one slice holds the write right and exactly one holds the read right at all times after reset. Slice 0, the slice with first-load low, holds both rights at reset.
- R6: When a slice accepts a write to its last location, the write right moves to the next slice in the ring on the same clock edge. Reads behave the same way, using a separate handoff strobe.
- R7: `rd_valid` is 1 in the cycle right after an accepted read, with the word on `rd_data`. In every other cycle `rd_data` is all zeros.
- R8: When the FIFO is full and read and write are requested in the same cycle, the read completes and the write is dropped. The FIFO is then no longer full.
- R9: The write and read rights wrap from the last slice back to slice 0 repeatedly under mixed traffic, and ordering is kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | OR of all slices' gated read data |
| rd_valid | output | 1 | A word was read in the previous cycle |
| full_n | output | 1 | Combined full flag, active low |
| empty_n | output | 1 | Combined empty flag, active low |

## Verification
The hardest case to reach is a handoff that happens while the FIFO is near one of its limits. An example is the write right wrapping onto a slice whose unread data is still waiting, so that slice must refuse writes while it is full. The bench reaches this case in two ways. It fills all slices and then issues a read and a write in the same cycle. It also runs long interleaved traffic with uneven write and read rates, so that both rights wrap the ring several times at varying occupancy. Every output word is compared with a queue model that applies the same acceptance rules.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

    // Per-slice status gathered by the top level
    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic wtok;
        logic rtok;
    } slice_stat_t;

    // Ring successor index
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1) % n;
    endfunction

    // Ring predecessor index
    function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
        return (idx + n - 1) % n;
    endfunction

endpackage

// File: rtl/slice_store.sv
module slice_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/slice_token_ctrl.sv
module slice_token_ctrl #(
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          first_ld_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          xi_wr,
    input  logic          xi_rd,
    output logic          xo_wr,
    output logic          xo_rd,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output chain_fifo_pkg::slice_stat_t stat
);
    logic [AW:0] wptr_q, rptr_q;
    logic        wtok_q, rtok_q;
    logic        is_full, is_empty, wr_last, rd_last;

    assign is_empty = (wptr_q == rptr_q);
    assign is_full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
    assign wr_last  = (wptr_q[AW-1:0] == AW'(DEPTH - 1));
    assign rd_last  = (rptr_q[AW-1:0] == AW'(DEPTH - 1));

    assign wr_go = wr_en && wtok_q && !is_full;
    assign rd_go = rd_en && rtok_q && !is_empty;
    assign xo_wr = wr_go && wr_last;
    assign xo_rd = rd_go && rd_last;

    assign waddr = wptr_q[AW-1:0];
    assign raddr = rptr_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            wtok_q <= !first_ld_n;
            rtok_q <= !first_ld_n;
        end else begin
            if (wr_go) wptr_q <= wptr_q + (AW+1)'(1);
            if (rd_go) rptr_q <= rptr_q + (AW+1)'(1);
            wtok_q <= (wtok_q && !xo_wr) || xi_wr;
            rtok_q <= (rtok_q && !xo_rd) || xi_rd;
        end
    end

    always_comb begin
        stat.full_n  = !is_full;
        stat.empty_n = !is_empty;
        stat.wtok    = wtok_q;
        stat.rtok    = rtok_q;
    end
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_ld_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr,
    output logic             xo_rd,
    output logic [WIDTH-1:0] q_gated,
    output logic             q_vld,
    output chain_fifo_pkg::slice_stat_t stat
);
    logic          wr_go, rd_go;
    logic [AW-1:0] waddr, raddr;
    logic [WIDTH-1:0] mem_q;
    logic [WIDTH-1:0] dout_q;
    logic             vld_q;

    slice_token_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .first_ld_n (first_ld_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .xi_wr      (xi_wr),
        .xi_rd      (xi_rd),
        .xo_wr      (xo_wr),
        .xo_rd      (xo_rd),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .waddr      (waddr),
        .raddr      (raddr),
        .stat       (stat)
    );

    slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    // Output register; output enable is the valid bit
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= rd_go;
            if (rd_go) dout_q <= mem_q;
        end
    end

    assign q_vld   = vld_q;
    assign q_gated = vld_q ? dout_q : '0;
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
    parameter int WIDTH       = 9,
    parameter int SLICE_DEPTH = 4,
    parameter int NSLICE      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             full_n,
    output logic             empty_n
);
    import chain_fifo_pkg::*;

    logic [NSLICE-1:0] xo_wr, xo_rd;
    logic [NSLICE-1:0] wtok_vec, rtok_vec, full_n_vec, empty_n_vec, vld_vec;
    logic [WIDTH-1:0]  q_arr [NSLICE];
    slice_stat_t       stat  [NSLICE];

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        localparam int unsigned PREV = ring_prev(i, NSLICE);

        fifo_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
            .clk        (clk),
            .rst        (rst),
            .first_ld_n ((i == 0) ? 1'b0 : 1'b1),
            .wr_en      (wr_en),
            .wr_data    (wr_data),
            .rd_en      (rd_en),
            .xi_wr      (xo_wr[PREV]),
            .xi_rd      (xo_rd[PREV]),
            .xo_wr      (xo_wr[i]),
            .xo_rd      (xo_rd[i]),
            .q_gated    (q_arr[i]),
            .q_vld      (vld_vec[i]),
            .stat       (stat[i])
        );

        assign wtok_vec[i]    = stat[i].wtok;
        assign rtok_vec[i]    = stat[i].rtok;
        assign full_n_vec[i]  = stat[i].full_n;
        assign empty_n_vec[i] = stat[i].empty_n;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSLICE; i++) rd_data = rd_data | q_arr[i];
    end

    assign rd_valid = |vld_vec;
    assign full_n   = |full_n_vec;
    assign empty_n  = |empty_n_vec;
endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
    parameter int WIDTH  = 9,
    parameter int NSLICE = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_valid,
    input logic              full_n,
    input logic              empty_n,
    input logic [NSLICE-1:0] wtok_vec,
    input logic [NSLICE-1:0] rtok_vec,
    input logic [NSLICE-1:0] xo_wr,
    input logic [NSLICE-1:0] xo_rd
);
    // R5
    wtok_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wtok_vec) == 1);

    // R5
    rtok_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rtok_vec) == 1);

    for (genvar i = 0; i < NSLICE; i++) begin : g_ring
        // R6
        wtok_pass_chk: assert property (@(posedge clk) disable iff (rst)
            xo_wr[i] |=> wtok_vec[(i + 1) % NSLICE]);

        // R6
        rtok_pass_chk: assert property (@(posedge clk) disable iff (rst)
            xo_rd[i] |=> rtok_vec[(i + 1) % NSLICE]);
    end

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !rd_en) |=> !full_n);

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en) |=> !rd_valid);

    // R4
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && !wr_en) |=> !empty_n);

    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    // R8
    full_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (!full_n && rd_en && wr_en) |=> (rd_valid && full_n));
endmodule

bind chain_fifo chain_fifo_chk #(.WIDTH(WIDTH), .NSLICE(NSLICE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .wtok_vec (wtok_vec),
    .rtok_vec (rtok_vec),
    .xo_wr    (xo_wr),
    .xo_rd    (xo_rd)
);

// File: tb/chain_fifo_test.sv
`timescale 1ns/1ps
module chain_fifo_test;
    localparam int WIDTH = 9;
    localparam int DEPTH = 4;
    localparam int NSL   = 3;
    localparam int CAP   = DEPTH * NSL;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid, full_n, empty_n;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] mq [$];
    logic [WIDTH-1:0] next_word = 9'd1;
    int rd_count = 0;

    always #2.5 clk = ~clk;

    chain_fifo #(.WIDTH(WIDTH), .SLICE_DEPTH(DEPTH), .NSLICE(NSL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n), .empty_n(empty_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock of stimulus plus checks against the queue model
    task automatic step(input logic we, input logic re, input string tag);
        logic [WIDTH-1:0] wd, exp_d;
        bit acc_w, acc_r;
        @(negedge clk);
        wd = next_word;
        wr_en = we; wr_data = wd; rd_en = re;
        acc_r = re && (mq.size() > 0);
        acc_w = we && (mq.size() < CAP);
        exp_d = '0;
        if (acc_r) exp_d = mq.pop_front();
        if (acc_w) mq.push_back(wd);
        if (we) next_word = next_word + 9'd1;
        if (next_word == '0) next_word = 9'd1;
        @(posedge clk); #1;
        check({tag, " valid"}, rd_valid, acc_r);
        if (acc_r) begin
            // reads crossing into a new slice exercise the handoff (R6)
            check((rd_count % DEPTH == 0) ? "R6 data" : {tag, " data"}, rd_data, exp_d);
            rd_count++;
        end else begin
            check("R7 idle bus", rd_data, 0);
        end
        check("R3 full_n", full_n, mq.size() != CAP);
        check("R4 empty_n", empty_n, mq.size() != 0);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 empty_n in reset", empty_n, 0);
        check("R1 full_n in reset", full_n, 1);
        @(negedge clk); rst = 1'b0; #1;
        check("R1 empty_n", empty_n, 0);
        check("R1 full_n", full_n, 1);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic test_fill_drain();
        for (int k = 0; k < CAP; k++) step(1'b1, 1'b0, "R2");
        check("R3 full after capacity", full_n, 0);
        step(1'b1, 1'b0, "R3");          // dropped write
        step(1'b1, 1'b0, "R3");          // dropped write
        for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, "R2");
        check("R4 empty after drain", empty_n, 0);
        step(1'b0, 1'b1, "R4");          // read while empty
        check("R4 no valid on empty read", rd_valid, 0);
        idle();
    endtask

    task automatic test_full_rw();
        for (int k = 0; k < CAP; k++) step(1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, "R8");
        check("R8 not full after read", full_n, 1);
        check("R8 read valid", rd_valid, 1);
        for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, "R8");
        check("R8 dropped word absent", empty_n, 0);
        idle();
    endtask

    task automatic test_stream();
        for (int k = 0; k < 90; k++) step((k % 3) != 2, (k % 2) == 0 || k > 60, "R9");
        for (int k = 0; k < 30; k++) step((k % 4) == 0, 1'b1, "R9");
        check("R9 drained", empty_n, 0);
        for (int k = 0; k < 50; k++) step(1'b1, (k % 5) == 0, "R9");
        for (int k = 0; k < CAP + 2; k++) step(1'b0, 1'b1, "R9");
        check("R9 drained again", empty_n, 0);
        idle();
    endtask

    task automatic test_single_word();
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R7");
        check("R7 bus zero after valid cycle", rd_data, 0);
        idle();
    endtask

    initial begin
        test_reset();
        test_single_word();
        test_fill_drain();
        test_full_rw();
        test_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule